// File: doc/BRIEF.md
# DMA End-of-Process Handler

This block looks after the active-low, open-drain end-of-process line of a DMA transfer sequencer. The sequencer reports its state on each clock: idle, or one of the five active transfer states S0 to S4. An external agent may pull the line low to stop a transfer early. The block synchronises the line and keeps a termination request only while the sequencer is active. It hands the request to the sequencer as a one-cycle terminate pulse in the next S2 state, and it drops the request if the sequencer goes idle before getting there.

The block also signals the end of a transfer to the outside. When the sequencer reports terminal count, the block pulls the line low for one S-state, which the sequencer advances once per clock. That pull-down returns through the block's own synchroniser. It is masked there so that the block does not take it for an external request.

Top module: `dma_eop_handler`

## Requirements
- R1: Reset, active low, releases the line (`eop_oe_o` = 0) and discards any held request, so no terminate pulse follows from a request seen before reset.
- R2: The line input `eop_pin_n_i` is active low and passes through two flip-flops. A low level sampled at clock edge k can therefore be held from edge k+2 onward, if the sequencer state is active in the cycle before that edge.
- R3: A low level on the line that reaches the synchroniser output while the state is idle (`state_i` = 3'd0) is ignored. The next S2 brings no terminate pulse.
- R4: A held request raises `terminate_o` for exactly the next cycle in which `state_i` is S2 (3'd3), and in no other state. Active-state codes are S0=3'd1, S1=3'd2, S2=3'd3, S3=3'd4, S4=3'd5.
- R5: Acting on a request clears it, so a later S2 produces no further pulse unless a new request arrives.
- R6: A held request is cleared without effect if the state returns to idle before S2 is reached.
- R7: `tc_i` high in a cycle drives `eop_oe_o` high in the following cycle only, for one S-state.
- R8: The block's own pull-down of the line, read back through the pin, is never taken as an external request.
- R9: `terminate_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one S-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_i | input | 3 | Sequencer state: 0 idle, 1..5 for S0..S4 |
| tc_i | input | 1 | Terminal count reached in this cycle |
| eop_pin_n_i | input | 1 | Level read back from the open-drain line, active low |
| eop_oe_o | output | 1 | 1 pulls the line low, 0 releases it |
| terminate_o | output | 1 | One-cycle pulse that ends the transfer |

## Verification
On every cycle, the assertions check that a terminate pulse occurs only in S2 and is never two cycles long. They check that idle and acting on a request both leave nothing held, that a synchronised request in an active state is held, and that the line is pulled low exactly in the cycle after terminal count. Only the bench scenarios can show the things that depend on a full sequence of states. These are whether an idle-time pulse, a request abandoned by a return to idle, or the block's own pull-down ever leads to a terminate at a later S2, and whether reset really discards a held request.

// File: rtl/dma_eop_pkg.sv
package dma_eop_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_S0   = 3'd1,
    ST_S1   = 3'd2,
    ST_S2   = 3'd3,
    ST_S3   = 3'd4,
    ST_S4   = 3'd5
  } seq_state_e;

  // True when the sequencer is in one of the transfer states S0..S4.
  function automatic logic state_is_active(input logic [STATE_W-1:0] s);
    return (s >= ST_S0) && (s <= ST_S4);
  endfunction

  // True in the state where a held request is handed to the sequencer.
  function automatic logic state_applies_eop(input logic [STATE_W-1:0] s);
    return s == ST_S2;
  endfunction

endpackage

// File: rtl/eop_sync.sv
module eop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eop_request_latch.sv
module eop_request_latch
  import dma_eop_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_i,
  input  logic               ext_seen_i,
  output logic               pending_o,
  output logic               fire_o
);
  logic active;
  assign active = state_is_active(state_i);
  assign fire_o = pending_o && state_applies_eop(state_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pending_o <= 1'b0;
    else if (!active)    pending_o <= 1'b0;
    else if (fire_o)     pending_o <= 1'b0;
    else if (ext_seen_i) pending_o <= 1'b1;
  end
endmodule

// File: rtl/eop_pulldown.sv
module eop_pulldown #(
  parameter int DRIVE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tc_i,
  output logic oe_o
);
  localparam int CW = $clog2(DRIVE_CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= '0;
    else if (tc_i)         remain <= CW'(DRIVE_CYCLES);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign oe_o = (remain != '0);
endmodule

// File: rtl/dma_eop_handler.sv
module dma_eop_handler
  import dma_eop_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DRIVE_CYCLES = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_i,
  input  logic               tc_i,
  input  logic               eop_pin_n_i,
  output logic               eop_oe_o,
  output logic               terminate_o
);
  logic line_low_sync;
  logic own_drive_dly;
  logic ext_seen;
  logic pending;

  eop_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(~eop_pin_n_i), .q(line_low_sync)
  );

  // Delays the pull-down enable by the synchroniser depth so it lines up
  // with the block's own low level coming back through the pin.
  eop_sync #(.STAGES(SYNC_STAGES)) u_own_dly (
    .clk(clk), .rst_n(rst_n), .d(eop_oe_o), .q(own_drive_dly)
  );

  assign ext_seen = line_low_sync && !own_drive_dly;

  eop_request_latch u_latch (
    .clk(clk), .rst_n(rst_n), .state_i(state_i),
    .ext_seen_i(ext_seen), .pending_o(pending), .fire_o(terminate_o)
  );

  eop_pulldown #(.DRIVE_CYCLES(DRIVE_CYCLES)) u_drive (
    .clk(clk), .rst_n(rst_n), .tc_i(tc_i), .oe_o(eop_oe_o)
  );
endmodule

// File: rtl/dma_eop_checker.sv
module dma_eop_checker
  import dma_eop_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [STATE_W-1:0] state_i,
  input logic               tc_i,
  input logic               eop_oe_o,
  input logic               terminate_o,
  input logic               ext_seen,
  input logic               pending
);
  a_r4_term_only_in_s2: assert property (@(posedge clk) disable iff (!rst_n)
    terminate_o |-> state_i == ST_S2);

  a_r9_term_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    terminate_o |=> !terminate_o);

  a_r5_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    terminate_o |=> !pending);

  a_r6_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_IDLE) |=> !pending);

  a_r2_active_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_seen && state_is_active(state_i) && !terminate_o) |=> pending);

  a_r7_drive_after_tc: assert property (@(posedge clk) disable iff (!rst_n)
    tc_i |=> eop_oe_o);

  a_r7_drive_needs_tc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eop_oe_o) |-> $past(tc_i));
endmodule

bind dma_eop_handler dma_eop_checker u_chk (
  .clk(clk), .rst_n(rst_n), .state_i(state_i), .tc_i(tc_i),
  .eop_oe_o(eop_oe_o), .terminate_o(terminate_o),
  .ext_seen(ext_seen), .pending(pending)
);

// File: tb/sim_dma_eop_handler.sv
module sim_dma_eop_handler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] state = 3'd0;
  logic       tc = 1'b0;
  logic       ext_low = 1'b0;
  logic       eop_oe;
  logic       term;
  logic       pin_n;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // Open-drain line: low if either side pulls it down.
  assign pin_n = ~(eop_oe | ext_low);

  dma_eop_handler u0 (
    .clk(clk), .rst_n(rst_n), .state_i(state), .tc_i(tc),
    .eop_pin_n_i(pin_n), .eop_oe_o(eop_oe), .terminate_o(term)
  );

  // {state[2:0], ext_low, tc, expected terminate, expected pull-down}
  localparam int NV = 42;
  localparam logic [6:0] VEC [0:NV-1] = '{
    7'b0011000, 7'b0100000, 7'b0110000, 7'b1000000, 7'b1010000, // request in S0
    7'b0010000, 7'b0100000, 7'b0110010, 7'b1000000, 7'b1010000, // acted on, cleared
    7'b0001000, 7'b0000000, 7'b0000000, 7'b0010000, 7'b0100000, // pulse while idle
    7'b0110000, 7'b1000000,
    7'b0011000, 7'b0100000, 7'b1000000, 7'b1010000, 7'b0000000, // dropped by idle
    7'b0010000, 7'b0100000, 7'b0110000, 7'b1000000,
    7'b1000100, 7'b1010001, 7'b0000000, 7'b0010000, 7'b0100000, // terminal count
    7'b0110000, 7'b1000000,
    7'b0011000, 7'b0100000, 7'b0110000, 7'b1000000, 7'b1010000, // held in S2
    7'b0010000, 7'b0100000, 7'b0110010, 7'b1000000
  };

  function automatic string tag_of(input int i);
    if (i < 10)      return "R4/R5 active request";
    else if (i < 17) return "R3 idle pulse";
    else if (i < 26) return "R6 idle before S2";
    else if (i < 33) return "R7/R8 terminal count";
    else             return "R2/R4 request at S2";
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] s, input logic e, input logic t);
    @(negedge clk);
    state = s; ext_low = e; tc = t;
    #2;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    drive(3'd3, 1'b0, 1'b0);
    check("R1", eop_oe, 1'b0, "pull-down during reset");
    check("R1", term, 1'b0, "terminate during reset");
    @(negedge clk) rst_n = 1'b1;
    drive(3'd0, 1'b0, 1'b0);
    check("R1", eop_oe, 1'b0, "pull-down after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][6:4], VEC[i][3], VEC[i][2]);
      check(tag_of(i), term, VEC[i][1], $sformatf("terminate, vector %0d", i));
      check(tag_of(i), eop_oe, VEC[i][0], $sformatf("pull-down, vector %0d", i));
    end

    // R1: a held request is discarded by reset.
    drive(3'd1, 1'b1, 1'b0);
    drive(3'd2, 1'b0, 1'b0);
    drive(3'd4, 1'b0, 1'b0);
    drive(3'd5, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    drive(3'd1, 1'b0, 1'b0);
    drive(3'd2, 1'b0, 1'b0);
    drive(3'd3, 1'b0, 1'b0);
    check("R1", term, 1'b0, "terminate after reset with held request");

    // R9: a request during S2 with the line held low for several cycles
    // still gives one pulse per S2 visit.
    drive(3'd1, 1'b1, 1'b0);
    drive(3'd2, 1'b1, 1'b0);
    drive(3'd4, 1'b0, 1'b0);
    drive(3'd3, 1'b0, 1'b0);
    check("R4", term, 1'b1, "terminate in S2 after request");
    drive(3'd3, 1'b0, 1'b0);
    check("R9", term, 1'b0, "terminate in second S2 cycle");
    drive(3'd0, 1'b0, 1'b0);

    // R8: back-to-back terminal counts never read back as a request.
    drive(3'd1, 1'b0, 1'b1);
    drive(3'd2, 1'b0, 1'b1);
    check("R7", eop_oe, 1'b1, "pull-down after terminal count");
    drive(3'd4, 1'b0, 1'b0);
    drive(3'd5, 1'b0, 1'b0);
    check("R7", eop_oe, 1'b0, "pull-down released");
    drive(3'd1, 1'b0, 1'b0);
    drive(3'd2, 1'b0, 1'b0);
    drive(3'd3, 1'b0, 1'b0);
    check("R8", term, 1'b0, "terminate from own pull-down");
    drive(3'd0, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule